// File: doc/BRIEF.md
# Double-to-Single Precision Narrowing Converter

This block narrows IEEE-754 binary64 values to binary32. A source vector carries `LANES` double lanes (two by default, lane 0 in the low 64 bits). In packed mode every double lane is converted. The results fill the low single lanes of the output, and the remaining upper single lanes are written as +0.0. In scalar mode only double lane 0 is converted, into single lane 0. Every other single lane is copied from a merge vector. The other source lanes have no effect on the data or on the flags.

Rounding of inexact results follows a 2-bit rounding-mode register. That register is written through a strobe and comes out of reset as round-to-nearest-even. The block handles overflow, tiny and subnormal results, NaNs, infinities and signed zeros. Exception flags are sticky: they gather across operations until `flag_clr` is pulsed.

A valid/ready handshake with one register stage separates input from output. A two-state machine controls it:
- `ST_EMPTY` means no result is held.
- `ST_FULL` means a result is waiting.

The transitions are:
- **take**: EMPTY→FULL, an operation is accepted.
- **refill**: FULL→FULL, the result is consumed and a new operation is accepted in the same cycle.
- **hold**: FULL→FULL, `out_ready` is low.
- **drain**: FULL→EMPTY, the result is consumed and nothing new arrives.

Top module: `dp2sp_narrow`

## Requirements
- R1: `in_ready` is high in `ST_EMPTY` and equals `out_ready` in `ST_FULL`. An operation accepted on a clock edge appears on `out_data` with `out_valid` high right after that edge. While `out_valid` is high and `out_ready` is low, `out_data` stays stable and no new operation is taken.
- R2: Packed mode (`in_scalar`=0) puts the conversion of double lane i into single lane i (bits 32i+31:32i). All higher single lanes are forced to 32'h00000000.
- R3: Scalar mode (`in_scalar`=1) converts only double lane 0 into single lane 0. Bits above 31 are copied from `in_merge`. The other source lanes affect neither the data nor the flags.
- R4: The rounding-mode register uses this encoding: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. It loads `rc_val` on a clock edge where `rc_wr` is high and resets to 00. Inexact results round by the mode held at the accepting edge.
- R5: A value that fits binary32 exactly is converted with no flag raised.
- R6: If the rounded magnitude exceeds the largest finite single, the result is one of two values:
  - infinity, when rounding to nearest or rounding away from zero in the value's direction;
  - otherwise 0x7F7FFFFF with the value's sign.

  Overflow and inexact are both raised, and this includes overflow caused by the rounding carry.
- R7: Values below the single normal range give correctly rounded subnormals or zero, and a rounding carry can lift the result to 0x00800000. Tininess is judged before rounding. The underflow flag is raised only when a tiny result is also inexact.
- R8: A NaN gives sign, exponent 0xFF, quiet bit 1 and the top 22 bits of the source fraction below the quiet bit. Invalid is raised only when the source quiet bit (bit 51) is 0.
- R9: Infinities and zeros keep their sign and raise no flag.
- R10: `flags` only gain bits until `flag_clr` is high on a clock edge. At that edge the old bits are dropped and only flags from an operation accepted at the same edge are kept.
- R11: The flag bits are laid out as follows:
  - bit 3: invalid
  - bit 2: overflow
  - bit 1: underflow
  - bit 0: inexact

  Any rounded result raises inexact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_wr | input | 1 | Rounding-mode register write strobe |
| rc_val | input | 2 | Rounding mode to load |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be accepted |
| in_scalar | input | 1 | 1 scalar mode, 0 packed mode |
| in_src | input | LANES*64 | Double source lanes |
| in_merge | input | LANES*64 | Single lanes copied through in scalar mode |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result consumed |
| out_data | output | LANES*64 | Single result lanes |
| flag_clr | input | 1 | Clears the sticky flags |
| flags | output | 4 | Sticky {invalid, overflow, underflow, inexact} |

## Verification
The assertions assume that `rst_n` is asserted until the inputs are at defined levels, and that the `in_*` fields are steady around each clock edge where `in_valid` is high. They also assume that `flag_clr` is a sampled level and not a glitch. The bench drives every input half a cycle away from the rising edge and keeps `in_valid` low during reset. It writes the rounding mode in a cycle of its own before each operation that depends on it.

// File: rtl/dp2sp_pkg.sv
package dp2sp_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hs_state_e;

    typedef struct packed {
        logic nv;   // invalid
        logic of;   // overflow
        logic uf;   // underflow
        logic nx;   // inexact
    } xflags_t;

    localparam int DBL_W     = 64;
    localparam int SGL_W     = 32;
    localparam int DBL_BIAS  = 1023;
    localparam int SGL_BIAS  = 127;
    // smallest double biased exponent that is still a normal single
    localparam int NORM_MIN_E = DBL_BIAS - SGL_BIAS + 1;
    // below this exponent every significand bit is shifted out
    localparam int ALL_LOST_E = NORM_MIN_E - 54;

endpackage

// File: rtl/dp2sp_lane.sv
module dp2sp_lane
    import dp2sp_pkg::*;
(
    input  logic [DBL_W-1:0] dbl,
    input  rmode_e           rm,
    output logic [SGL_W-1:0] sgl,
    output xflags_t          flg
);

    logic        sgn;
    logic [10:0] ex;
    logic [51:0] fr;
    logic        nonfin;
    logic        in_norm;
    logic [5:0]  sh;
    logic [52:0] sig;
    logic [52:0] sig_sh;
    logic        lost;
    logic [23:0] kept;
    logic        guard;
    logic        stk;
    logic        rnd_any;
    logic        inc;
    logic [24:0] rnd;
    logic [11:0] bexp;
    logic        ovf;
    logic        to_inf;

    always_comb begin
        sgn     = dbl[63];
        ex      = dbl[62:52];
        fr      = dbl[51:0];
        nonfin  = &ex;
        in_norm = (ex >= 11'(NORM_MIN_E));

        if (in_norm)
            sh = 6'd0;
        else if (ex <= 11'(ALL_LOST_E))
            sh = 6'd54;
        else
            sh = 6'(11'(NORM_MIN_E) - ex);

        sig     = {|ex, fr};
        sig_sh  = sig >> sh;
        lost    = |(sig & ~({53{1'b1}} << sh));
        kept    = sig_sh[52:29];
        guard   = sig_sh[28];
        stk     = (|sig_sh[27:0]) | lost;
        rnd_any = guard | stk;

        unique case (rm)
            RM_NEAR: inc = guard & (stk | kept[0]);
            RM_DOWN: inc = sgn & rnd_any;
            RM_UP:   inc = ~sgn & rnd_any;
            RM_ZERO: inc = 1'b0;
        endcase

        rnd  = {1'b0, kept} + 25'(inc);
        bexp = (in_norm ? (12'(ex) - 12'(NORM_MIN_E)) : 12'd0) + 12'(rnd[24:23]);
        ovf  = in_norm && (bexp >= 12'd255);

        to_inf = (rm == RM_NEAR) || (rm == RM_DOWN && sgn) || (rm == RM_UP && !sgn);

        flg = '0;
        if (nonfin) begin
            if (fr == '0) begin
                sgl = {sgn, 8'hFF, 23'd0};
            end else begin
                sgl    = {sgn, 8'hFF, 1'b1, fr[50:29]};
                flg.nv = ~fr[51];
            end
        end else if (ovf) begin
            sgl    = to_inf ? {sgn, 8'hFF, 23'd0} : {sgn, 8'hFE, {23{1'b1}}};
            flg.of = 1'b1;
            flg.nx = 1'b1;
        end else begin
            sgl    = {sgn, bexp[7:0], rnd[22:0]};
            flg.nx = rnd_any;
            flg.uf = ~in_norm & rnd_any;
        end
    end

endmodule

// File: rtl/dp2sp_flagacc.sv
module dp2sp_flagacc
    import dp2sp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  logic    upd,
    input  xflags_t new_f,
    output xflags_t acc_f
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_f <= '0;
        else
            acc_f <= (clr ? xflags_t'('0) : acc_f) | (upd ? new_f : xflags_t'('0));
    end

endmodule

// File: rtl/dp2sp_narrow.sv
module dp2sp_narrow
    import dp2sp_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rc_wr,
    input  logic [1:0]         rc_val,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic               in_scalar,
    input  logic [LANES*64-1:0] in_src,
    input  logic [LANES*64-1:0] in_merge,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [LANES*64-1:0] out_data,
    input  logic               flag_clr,
    output logic [3:0]         flags
);

    localparam int VEC_W = LANES * DBL_W;

    hs_state_e          state_q;
    hs_state_e          state_d;
    rmode_e             rm_q;
    logic               take;
    logic [SGL_W-1:0]   cvt [LANES];
    xflags_t            lane_f [LANES];
    logic [VEC_W-1:0]   nxt_data;
    xflags_t            nxt_f;
    xflags_t            acc_f;
    logic               merge_lo_unused;

    assign merge_lo_unused = ^in_merge[SGL_W-1:0];

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            dp2sp_lane u_lane (
                .dbl (in_src[g*DBL_W +: DBL_W]),
                .rm  (rm_q),
                .sgl (cvt[g]),
                .flg (lane_f[g])
            );
        end
    endgenerate

    // lane placement per mode
    always_comb begin
        if (in_scalar) begin
            nxt_data = {in_merge[VEC_W-1:SGL_W], cvt[0]};
            nxt_f    = lane_f[0];
        end else begin
            nxt_data = '0;
            nxt_f    = '0;
            for (int i = 0; i < LANES; i++) begin
                nxt_data[i*SGL_W +: SGL_W] = cvt[i];
                nxt_f                      = nxt_f | lane_f[i];
            end
        end
    end

    // handshake decode
    always_comb begin
        unique case (state_q)
            ST_EMPTY: in_ready = 1'b1;
            ST_FULL:  in_ready = out_ready;
        endcase
    end

    assign take      = in_valid && in_ready;
    assign out_valid = (state_q == ST_FULL);

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = take ? ST_FULL : ST_EMPTY;          // take
            ST_FULL:  state_d = (out_ready && !take) ? ST_EMPTY     // drain
                                                     : ST_FULL;     // hold / refill
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_EMPTY;
        else
            state_q <= state_d;
    end

    // output and mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
            rm_q     <= RM_NEAR;
        end else begin
            if (take)
                out_data <= nxt_data;
            if (rc_wr)
                rm_q <= rmode_e'(rc_val);
        end
    end

    dp2sp_flagacc u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (flag_clr),
        .upd   (take),
        .new_f (nxt_f),
        .acc_f (acc_f)
    );

    assign flags = acc_f;

endmodule

// File: rtl/dp2sp_narrow_chk.sv
module dp2sp_narrow_chk #(
    parameter int LANES = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_ready,
    input logic               in_scalar,
    input logic [LANES*64-1:0] in_merge,
    input logic               out_valid,
    input logic               out_ready,
    input logic [LANES*64-1:0] out_data,
    input logic               flag_clr,
    input logic [3:0]         flags
);

    localparam int W = LANES * 64;

    assert_accept_fills_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_pack_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_scalar) |=> (out_data[W-1:W/2] == '0));

    assert_scalar_merge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_scalar) |=> (out_data[W-1:32] == $past(in_merge[W-1:32])));

    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((flags & $past(flags)) == $past(flags)));

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(in_valid && in_ready)) |=> (flags == 4'd0));

    assert_of_implies_nx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flags[2] |-> flags[0]);

    assert_uf_implies_nx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1] |-> flags[0]);

endmodule

bind dp2sp_narrow dp2sp_narrow_chk #(.LANES(LANES)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_scalar (in_scalar),
    .in_merge  (in_merge),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .flag_clr  (flag_clr),
    .flags     (flags)
);

// File: tb/dp2sp_narrow_tb_top.sv
`timescale 1ns/1ps
module dp2sp_narrow_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rc_wr = 1'b0;
    logic [1:0]   rc_val = 2'b00;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_scalar = 1'b0;
    logic [127:0] in_src = '0;
    logic [127:0] in_merge = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_data;
    logic         flag_clr = 1'b0;
    logic [3:0]   flags;

    int n_run  = 0;
    int n_fail = 0;

    localparam logic [63:0] ONE  = 64'h3FF0000000000000;
    localparam logic [63:0] TIEP = 64'h3FF0000010000000;
    localparam logic [63:0] TIEN = 64'hBFF0000010000000;

    always #2.5 clk = ~clk;

    dp2sp_narrow #(.LANES(2)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rc_wr     (rc_wr),
        .rc_val    (rc_val),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_scalar (in_scalar),
        .in_src    (in_src),
        .in_merge  (in_merge),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .flag_clr  (flag_clr),
        .flags     (flags)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_rm(input logic [1:0] v);
        @(negedge clk);
        rc_wr = 1'b1; rc_val = v;
        @(negedge clk);
        rc_wr = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic issue(input logic sc, input logic [63:0] l1, input logic [63:0] l0,
                         input logic [127:0] mrg);
        @(negedge clk);
        in_scalar = sc; in_src = {l1, l0}; in_merge = mrg; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic conv(input string tag, input logic sc, input logic [63:0] l1,
                        input logic [63:0] l0, input logic [127:0] mrg,
                        input logic [127:0] exp_d, input logic [3:0] exp_f);
        pulse_clear();
        issue(sc, l1, l0, mrg);
        chk({tag, " valid"}, 128'(out_valid), 128'd1);
        chk({tag, " data"}, out_data, exp_d);
        chk({tag, " flags"}, 128'(flags), 128'(exp_f));
    endtask

    task automatic t_reset();
        chk("R1 reset out_valid", 128'(out_valid), 128'd0);
        chk("R1 reset in_ready", 128'(in_ready), 128'd1);
        chk("R10 reset flags", 128'(flags), 128'd0);
    endtask

    task automatic t_reset_round();
        // R4: default mode after reset is nearest-even
        conv("R4 reset mode nearest", 1'b0, 64'h3FF0000030000000, TIEP, '0,
             {64'd0, 32'h3F800002, 32'h3F800000}, 4'b0001);
    endtask

    task automatic t_packed_exact();
        conv("R2 R5 packed exact", 1'b0, 64'hC004000000000000, ONE, '1,
             {64'd0, 32'hC0200000, 32'h3F800000}, 4'b0000);
    endtask

    task automatic t_round_modes();
        set_rm(2'b01);
        conv("R4 toward minus", 1'b0, TIEN, TIEP, '0, {64'd0, 32'hBF800001, 32'h3F800000}, 4'b0001);
        set_rm(2'b10);
        conv("R4 toward plus", 1'b0, TIEN, TIEP, '0, {64'd0, 32'hBF800000, 32'h3F800001}, 4'b0001);
        set_rm(2'b11);
        conv("R4 toward zero", 1'b0, TIEN, TIEP, '0, {64'd0, 32'hBF800000, 32'h3F800000}, 4'b0001);
        set_rm(2'b00);
        conv("R11 nearest inexact", 1'b0, TIEN, TIEP, '0, {64'd0, 32'hBF800000, 32'h3F800000}, 4'b0001);
    endtask

    task automatic t_overflow();
        set_rm(2'b11);
        conv("R6 ovf toward zero", 1'b0, 64'hC7F0000000000000, 64'h47F0000000000000, '0,
             {64'd0, 32'hFF7FFFFF, 32'h7F7FFFFF}, 4'b0101);
        conv("R6 carry no ovf toward zero", 1'b0, ONE, 64'h47EFFFFFFFFFFFFF, '0,
             {64'd0, 32'h3F800000, 32'h7F7FFFFF}, 4'b0001);
        set_rm(2'b10);
        conv("R6 ovf toward plus", 1'b0, 64'hC7F0000000000000, 64'h47F0000000000000, '0,
             {64'd0, 32'hFF7FFFFF, 32'h7F800000}, 4'b0101);
        set_rm(2'b01);
        conv("R6 ovf toward minus", 1'b0, 64'hC7F0000000000000, 64'h47F0000000000000, '0,
             {64'd0, 32'hFF800000, 32'h7F7FFFFF}, 4'b0101);
        set_rm(2'b00);
        conv("R6 carry ovf nearest", 1'b0, ONE, 64'h47EFFFFFFFFFFFFF, '0,
             {64'd0, 32'h3F800000, 32'h7F800000}, 4'b0101);
    endtask

    task automatic t_subnormal();
        conv("R7 min subnormal exact", 1'b0, 64'h3810000000000000, 64'h36A0000000000000, '0,
             {64'd0, 32'h00800000, 32'h00000001}, 4'b0000);
        conv("R7 half min nearest", 1'b0, ONE, 64'h3690000000000000, '0,
             {64'd0, 32'h3F800000, 32'h00000000}, 4'b0011);
        conv("R7 carry into normal", 1'b0, ONE, 64'h380FFFFFFFFFFFFF, '0,
             {64'd0, 32'h3F800000, 32'h00800000}, 4'b0011);
        conv("R7 R9 dbl subnormal nearest", 1'b0, ONE, 64'h8000000000000001, '0,
             {64'd0, 32'h3F800000, 32'h80000000}, 4'b0011);
        set_rm(2'b10);
        conv("R7 half min toward plus", 1'b0, ONE, 64'h3690000000000000, '0,
             {64'd0, 32'h3F800000, 32'h00000001}, 4'b0011);
        conv("R7 dbl subnormal toward plus", 1'b0, ONE, 64'h0000000000000001, '0,
             {64'd0, 32'h3F800000, 32'h00000001}, 4'b0011);
        set_rm(2'b00);
    endtask

    task automatic t_nan();
        conv("R8 signalling NaN", 1'b0, ONE, 64'h7FF4000020000000, '0,
             {64'd0, 32'h3F800000, 32'h7FE00001}, 4'b1000);
        conv("R8 quiet NaN", 1'b0, 64'hFFF8000000000000, ONE, '0,
             {64'd0, 32'hFFC00000, 32'h3F800000}, 4'b0000);
    endtask

    task automatic t_special();
        conv("R9 minus inf and minus zero", 1'b0, 64'h8000000000000000, 64'hFFF0000000000000, '0,
             {64'd0, 32'h80000000, 32'hFF800000}, 4'b0000);
        conv("R9 plus inf and plus zero", 1'b0, 64'h7FF0000000000000, 64'h0, '0,
             {64'd0, 32'h7F800000, 32'h00000000}, 4'b0000);
    endtask

    task automatic t_scalar();
        // R3: lane 1 is a signalling NaN and must not raise invalid
        conv("R3 scalar merge", 1'b1, 64'h7FF0000000000001, ONE,
             128'h0123456789ABCDEF_FEDCBA98_76543210,
             {96'h0123456789ABCDEF_FEDCBA98, 32'h3F800000}, 4'b0000);
    endtask

    task automatic t_sticky();
        pulse_clear();
        issue(1'b0, ONE, TIEP, '0);
        issue(1'b0, ONE, ONE, '0);
        chk("R10 sticky after exact", 128'(flags), 128'(4'b0001));
        issue(1'b0, ONE, 64'h7FF0000000000001, '0);
        chk("R10 sticky accumulate", 128'(flags), 128'(4'b1001));
        // clear and overflow accepted on the same edge
        @(negedge clk);
        flag_clr = 1'b1; in_scalar = 1'b0; in_src = {ONE, 64'h47F0000000000000}; in_valid = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0; in_valid = 1'b0;
        chk("R10 clear with accept", 128'(flags), 128'(4'b0101));
        pulse_clear();
        chk("R10 clear", 128'(flags), 128'd0);
    endtask

    task automatic t_backpressure();
        @(negedge clk);
        out_ready = 1'b0;
        issue(1'b0, ONE, ONE, '0);
        @(negedge clk);
        in_scalar = 1'b0; in_src = {64'hC004000000000000, 64'hC004000000000000}; in_valid = 1'b1;
        #0.1;
        chk("R1 in_ready low while full", 128'(in_ready), 128'd0);
        repeat (3) @(negedge clk);
        chk("R1 held data", out_data, {64'd0, 32'h3F800000, 32'h3F800000});
        chk("R1 held valid", 128'(out_valid), 128'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 refill data", out_data, {64'd0, 32'hC0200000, 32'hC0200000});
        chk("R1 refill valid", 128'(out_valid), 128'd1);
        @(negedge clk);
        chk("R1 drained", 128'(out_valid), 128'd0);
    endtask

    initial begin : watchdog
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reset_round();
        t_packed_exact();
        t_round_modes();
        t_overflow();
        t_subnormal();
        t_nan();
        t_special();
        t_scalar();
        t_sticky();
        t_backpressure();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule